// File: doc/BRIEF.md
# Sliding-Mode Current and Back-EMF Observer

This block estimates the stator currents and the back-EMF of a surface-mount permanent-magnet motor in the stationary two-axis (alpha/beta) frame. The control loop raises a one-cycle sample strobe once per control period. The block then captures the measured currents and the applied voltages and runs a short fixed sequence of multiply-accumulate steps. At the end it publishes new current and back-EMF estimates together with a one-cycle valid pulse. The sequence takes eight clock cycles, which is a small part of a 10 µs sample period at any usual clock rate.

The current predictor feeds the estimated back-EMF straight back into the voltage balance. It does not filter the back-EMF out of the switching term. The switching law is a smooth, odd, piecewise-linear tanh shape instead of a hard sign function. The back-EMF estimate is corrected from the present current error and the error of the previous sample. A host loads the decay factor A, the input gain B, its inverse, the sliding gain k (0.5 in the intended use), the step size µ and the tanh slope. The host may change them only between a valid pulse and the next strobe.

Top module: `smo_observer`

## Requirements
- R1: A synchronous active-low reset clears both current estimates, both back-EMF estimates, both stored previous errors and valid_o to zero.
- R2: Signals are 16-bit two's-complement Q1.15. The per-axis current error is the estimate minus the measurement, saturated to [-32768, 32767].
- R3: The switching function takes x and the unsigned Q4.12 slope g. It forms a = (|x|·g) >> 12 and gives a when a < 16384, 8192 + (a >> 1) when a < 49152, and 32767 otherwise. The result takes the sign of x, so the function is odd.
- R4: The new current estimate is sat((A·î + B·v) >>> 12). Here v = sat(u − ê − kz) and kz = sat((k·tanh(ĩ)) >>> 12). A, B and k are signed Q4.12, and >>> is an arithmetic (floor) shift.
- R5: The new back-EMF estimate is sat(ê + sat((µ·d) >>> 12)). Here d = sat((B⁻¹·ĩ − A·ĩprev + (kzprev << 12)) >>> 12) and kzprev = sat((k·tanh(ĩprev)) >>> 12). B⁻¹ and µ are signed Q4.12.
- R6: Each axis stores exactly one previous error, the one from the last completed update. It is zero after reset.
- R7: The alpha and beta axes use identical equations and do not affect each other. An axis with zero state and zero inputs stays at zero.
- R8: valid_o is high for exactly one cycle, 7 rising edges after the edge that accepts a strobe. The four estimate outputs change only on that same edge and hold at all other times.
- R9: A strobe that arrives while an update is in progress is ignored. Its data has no effect, and no extra valid pulse follows.
- R10: Every sum and product is saturated to the 16-bit range and never wraps. For example, with A = 0, B = 4.0 and zero state, u = 32767 gives î = 32767 and u = −32768 gives î = −32768.
- R11: The coefficient inputs are read during the update sequence. They must remain unchanged from the accepting edge until valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 1 | Sample strobe, starts one update |
| imeas_alpha_i | input | 16 | Measured alpha current, Q1.15 |
| imeas_beta_i | input | 16 | Measured beta current, Q1.15 |
| vapp_alpha_i | input | 16 | Applied alpha voltage, Q1.15 |
| vapp_beta_i | input | 16 | Applied beta voltage, Q1.15 |
| cf_decay_i | input | 16 | A = 1 − R·Ts/L, signed Q4.12 |
| cf_gain_i | input | 16 | B = Ts/L, signed Q4.12 |
| cf_inv_gain_i | input | 16 | B⁻¹ ≈ L/Ts, signed Q4.12 |
| cf_slide_i | input | 16 | Sliding gain k, signed Q4.12 |
| cf_step_i | input | 16 | EMF step size µ, signed Q4.12 |
| cf_slope_i | input | 16 | tanh input slope, unsigned Q4.12 |
| iest_alpha_o | output | 16 | Estimated alpha current |
| iest_beta_o | output | 16 | Estimated beta current |
| emf_alpha_o | output | 16 | Estimated alpha back-EMF |
| emf_beta_o | output | 16 | Estimated beta back-EMF |
| valid_o | output | 1 | One-cycle pulse when new estimates are out |

## Verification
The checker assumes that the coefficient inputs stay constant for the whole time an update is in flight. It also assumes that a strobe accepted while the block is idle is the only event that starts the latency count. The bench changes coefficients only after a valid pulse and before the next strobe. The bench does inject one strobe during a busy sequence, with different data, to confirm that the data is dropped without breaking the latency property. Measured and applied values span all three tanh segments in both signs and reach both rails, so the saturation points are exercised.

// File: rtl/smo_pkg.sv
// Shared definitions for the sliding-mode observer.
// Assumes two stationary-frame axes, each handled by an identical lane.
package smo_pkg;
    localparam int NUM_AXES = 2;

    // Steps of the per-axis update sequence, in execution order.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KZ,
        ST_KZP,
        ST_PRED0,
        ST_PRED1,
        ST_EMF0,
        ST_EMF1,
        ST_EMF2
    } step_e;
endpackage

// File: rtl/smo_tanh.sv
// Odd piecewise-linear tanh approximation.
// The input is scaled by an unsigned Q4.12 slope. The result has unit slope
// up to one half, then half slope, and clips to full scale beyond 1.5.
// Assumes a Q1.(DW-1) input and output.
module smo_tanh #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int CF = 12
) (
    input  logic signed [DW-1:0] x_i,
    input  logic        [CW-1:0] slope_i,
    output logic signed [DW-1:0] y_o
);
    localparam int PWID = DW + 1 + CW;
    localparam int TW   = PWID - CF;
    localparam logic [TW-1:0] HALF = TW'(2 ** (DW - 2));
    localparam logic [TW-1:0] QTR  = TW'(2 ** (DW - 3));
    localparam logic [TW-1:0] KNEE = TW'(3 * (2 ** (DW - 2)));
    localparam logic [TW-1:0] ONE  = TW'((2 ** (DW - 1)) - 1);

    logic signed [DW:0]   xs;
    logic        [DW:0]   xm;
    logic        [PWID-1:0] prod;
    logic        [TW-1:0] a;
    logic        [TW-1:0] ymag;

    // Magnitude, scale, segment select, then restore the sign.
    always_comb begin
        xs   = (DW+1)'(x_i);
        xm   = xs[DW] ? $unsigned(-xs) : $unsigned(xs);
        prod = PWID'(xm) * PWID'(slope_i);
        a    = prod[PWID-1:CF];
        if (a < HALF)      ymag = a;
        else if (a < KNEE) ymag = QTR + (a >> 1);
        else               ymag = ONE;
        y_o = xs[DW] ? -$signed(ymag[DW-1:0]) : $signed(ymag[DW-1:0]);
    end
endmodule

// File: rtl/smo_axis.sv
// One observer axis: current predictor and back-EMF corrector.
// A start pulse captures the measurement and voltage. Seven more steps share
// one multiplier, and the last step commits the new estimates and pulses done.
// Assumes the coefficients are stable from start to done.
module smo_axis
    import smo_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int CF = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic signed [DW-1:0] meas_i,
    input  logic signed [DW-1:0] volt_i,
    input  logic signed [CW-1:0] a_i,
    input  logic signed [CW-1:0] b_i,
    input  logic signed [CW-1:0] binv_i,
    input  logic signed [CW-1:0] k_i,
    input  logic signed [CW-1:0] mu_i,
    input  logic        [CW-1:0] slope_i,
    output logic signed [DW-1:0] iest_o,
    output logic signed [DW-1:0] eest_o,
    output logic                 busy_o,
    output logic                 done_o
);
    localparam int PW = DW + CW;
    localparam int AW = PW + 2;
    localparam logic signed [AW-1:0] SMAX = AW'((2 ** (DW - 1)) - 1);
    localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);

    step_e step;
    logic signed [DW-1:0] iest, eest, err_now, err_prev, volt_q;
    logic signed [DW-1:0] kz_now, kz_prev, i_next, dcorr;
    logic signed [AW-1:0] acc;
    logic                 done_q;

    logic signed [DW-1:0] tanh_in, tanh_y, ms, v_sat;
    logic signed [CW-1:0] mc;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext, kzp_w, v_sum, e_sum;

    // Clamp a wide signed value into the signal range.
    function automatic logic signed [DW-1:0] sat_dw(input logic signed [AW-1:0] x);
        if (x > SMAX)      return SMAX[DW-1:0];
        else if (x < SMIN) return SMIN[DW-1:0];
        else               return x[DW-1:0];
    endfunction

    assign tanh_in = (step == ST_KZP) ? err_prev : err_now;

    smo_tanh #(.DW(DW), .CW(CW), .CF(CF)) tanh_i (
        .x_i     (tanh_in),
        .slope_i (slope_i),
        .y_o     (tanh_y)
    );

    // Operand select for the shared multiplier and the derived sums.
    always_comb begin
        mc = '0;
        ms = '0;
        case (step)
            ST_KZ, ST_KZP: begin mc = k_i;    ms = tanh_y;   end
            ST_PRED0:      begin mc = a_i;    ms = iest;     end
            ST_PRED1:      begin mc = b_i;    ms = v_sat;    end
            ST_EMF0:       begin mc = binv_i; ms = err_now;  end
            ST_EMF1:       begin mc = a_i;    ms = err_prev; end
            ST_EMF2:       begin mc = mu_i;   ms = dcorr;    end
            default:       begin mc = '0;     ms = '0;       end
        endcase
        prod     = PW'(mc) * PW'(ms);
        prod_ext = AW'(prod);
        kzp_w    = AW'(kz_prev) <<< CF;
        v_sum    = AW'(volt_q) - AW'(eest) - AW'(kz_now);
        v_sat    = sat_dw(v_sum);
        e_sum    = AW'(eest) + AW'(sat_dw(prod_ext >>> CF));
    end

    // Sequencer and state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step     <= ST_IDLE;
            iest     <= '0;
            eest     <= '0;
            err_now  <= '0;
            err_prev <= '0;
            volt_q   <= '0;
            kz_now   <= '0;
            kz_prev  <= '0;
            i_next   <= '0;
            dcorr    <= '0;
            acc      <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (step)
                ST_IDLE: if (start_i) begin
                    err_now <= sat_dw(AW'(iest) - AW'(meas_i));
                    volt_q  <= volt_i;
                    step    <= ST_KZ;
                end
                ST_KZ: begin
                    kz_now <= sat_dw(prod_ext >>> CF);
                    step   <= ST_KZP;
                end
                ST_KZP: begin
                    kz_prev <= sat_dw(prod_ext >>> CF);
                    step    <= ST_PRED0;
                end
                ST_PRED0: begin
                    acc  <= prod_ext;
                    step <= ST_PRED1;
                end
                ST_PRED1: begin
                    i_next <= sat_dw((acc + prod_ext) >>> CF);
                    step   <= ST_EMF0;
                end
                ST_EMF0: begin
                    acc  <= prod_ext;
                    step <= ST_EMF1;
                end
                ST_EMF1: begin
                    dcorr <= sat_dw((acc - prod_ext + kzp_w) >>> CF);
                    step  <= ST_EMF2;
                end
                ST_EMF2: begin
                    eest     <= sat_dw(e_sum);
                    iest     <= i_next;
                    err_prev <= err_now;
                    done_q   <= 1'b1;
                    step     <= ST_IDLE;
                end
                default: step <= ST_IDLE;
            endcase
        end
    end

    assign iest_o = iest;
    assign eest_o = eest;
    assign busy_o = (step != ST_IDLE);
    assign done_o = done_q;
endmodule

// File: rtl/smo_observer.sv
// Two-axis sliding-mode current and back-EMF observer, top level.
// Fans the sample strobe and the shared coefficients out to identical lanes
// and combines their completion into one valid pulse.
// Assumes the host changes coefficients only while the block is idle.
module smo_observer
    import smo_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int CF = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_i,
    input  logic signed [DW-1:0] imeas_alpha_i,
    input  logic signed [DW-1:0] imeas_beta_i,
    input  logic signed [DW-1:0] vapp_alpha_i,
    input  logic signed [DW-1:0] vapp_beta_i,
    input  logic signed [CW-1:0] cf_decay_i,
    input  logic signed [CW-1:0] cf_gain_i,
    input  logic signed [CW-1:0] cf_inv_gain_i,
    input  logic signed [CW-1:0] cf_slide_i,
    input  logic signed [CW-1:0] cf_step_i,
    input  logic        [CW-1:0] cf_slope_i,
    output logic signed [DW-1:0] iest_alpha_o,
    output logic signed [DW-1:0] iest_beta_o,
    output logic signed [DW-1:0] emf_alpha_o,
    output logic signed [DW-1:0] emf_beta_o,
    output logic                 valid_o
);
    logic signed [DW-1:0] meas_v [NUM_AXES];
    logic signed [DW-1:0] volt_v [NUM_AXES];
    logic signed [DW-1:0] iest_v [NUM_AXES];
    logic signed [DW-1:0] eest_v [NUM_AXES];
    logic [NUM_AXES-1:0]  lane_busy;
    logic [NUM_AXES-1:0]  lane_done;
    logic                 busy_any;

    assign meas_v[0] = imeas_alpha_i;
    assign meas_v[1] = imeas_beta_i;
    assign volt_v[0] = vapp_alpha_i;
    assign volt_v[1] = vapp_beta_i;

    for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
        smo_axis #(.DW(DW), .CW(CW), .CF(CF)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (sample_i),
            .meas_i  (meas_v[ax]),
            .volt_i  (volt_v[ax]),
            .a_i     (cf_decay_i),
            .b_i     (cf_gain_i),
            .binv_i  (cf_inv_gain_i),
            .k_i     (cf_slide_i),
            .mu_i    (cf_step_i),
            .slope_i (cf_slope_i),
            .iest_o  (iest_v[ax]),
            .eest_o  (eest_v[ax]),
            .busy_o  (lane_busy[ax]),
            .done_o  (lane_done[ax])
        );
    end

    assign busy_any     = |lane_busy;
    assign valid_o      = &lane_done;
    assign iest_alpha_o = iest_v[0];
    assign iest_beta_o  = iest_v[1];
    assign emf_alpha_o  = eest_v[0];
    assign emf_beta_o   = eest_v[1];
endmodule

// File: rtl/smo_observer_chk.sv
// Timing and reset properties of the observer, bound to its top level.
// Assumes the busy indication is taken from the lanes' sequencers.
module smo_observer_chk #(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_i,
    input logic                 busy_i,
    input logic                 valid_i,
    input logic signed [DW-1:0] iest_a,
    input logic signed [DW-1:0] iest_b,
    input logic signed [DW-1:0] emf_a,
    input logic signed [DW-1:0] emf_b,
    input logic signed [CW-1:0] c_decay,
    input logic signed [CW-1:0] c_gain,
    input logic signed [CW-1:0] c_inv,
    input logic signed [CW-1:0] c_slide,
    input logic signed [CW-1:0] c_step,
    input logic        [CW-1:0] c_slope
);
    localparam logic [3:0] LAT = 4'd8;
    logic [3:0] lat_cnt;

    // Counts cycles since an idle strobe was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                    lat_cnt <= '0;
        else if (sample_i && !busy_i)  lat_cnt <= 4'd1;
        else if (valid_i)              lat_cnt <= '0;
        else if (lat_cnt != 4'd0 && lat_cnt != 4'hF) lat_cnt <= lat_cnt + 4'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (iest_a == '0 && iest_b == '0 && emf_a == '0 && emf_b == '0 && !valid_i));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> !valid_i);

    // R8 R9
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> (lat_cnt == LAT));

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && $past(rst_n)) |->
            ($stable(iest_a) && $stable(iest_b) && $stable(emf_a) && $stable(emf_b)));

    // R11
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |->
            ($stable(c_decay) && $stable(c_gain) && $stable(c_inv) &&
             $stable(c_slide) && $stable(c_step) && $stable(c_slope)));
endmodule

bind smo_observer smo_observer_chk #(.DW(DW), .CW(CW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample_i),
    .busy_i   (busy_any),
    .valid_i  (valid_o),
    .iest_a   (iest_alpha_o),
    .iest_b   (iest_beta_o),
    .emf_a    (emf_alpha_o),
    .emf_b    (emf_beta_o),
    .c_decay  (cf_decay_i),
    .c_gain   (cf_gain_i),
    .c_inv    (cf_inv_gain_i),
    .c_slide  (cf_slide_i),
    .c_step   (cf_step_i),
    .c_slope  (cf_slope_i)
);

// File: tb/smo_observer_tb_top.sv
// Self-checking bench: a stimulus table walked in one loop, then directed
// tests for reset, a busy strobe, axis independence and saturation.
module smo_observer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // imeas_alpha, imeas_beta, vapp_alpha, vapp_beta
    localparam int VEC [NVEC][4] = '{
        '{  1000,  -1000,  4000,  -4000},
        '{ -6000,   6000,  2000,   3000},
        '{ 12000, -15000, -5000,   8000},
        '{-20000,  20000, 10000, -10000},
        '{ 30000, -32768, 32767, -32768},
        '{     0,    500,  -100,    250}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample = 1'b0;
    logic signed [15:0] im_a = '0, im_b = '0, u_a = '0, u_b = '0;
    logic signed [15:0] c_a = 16'sd3891, c_b = 16'sd2048, c_bi = 16'sd8192;
    logic signed [15:0] c_k = 16'sd2048, c_mu = 16'sd1024;
    logic        [15:0] c_g = 16'd8192;
    logic signed [15:0] ie_a, ie_b, ee_a, ee_b;
    logic valid;

    int n_total = 0;
    int n_bad = 0;
    longint m_ie [2], m_ee [2], m_ep [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    smo_observer dut_i (
        .clk(clk), .rst_n(rst_n), .sample_i(sample),
        .imeas_alpha_i(im_a), .imeas_beta_i(im_b),
        .vapp_alpha_i(u_a), .vapp_beta_i(u_b),
        .cf_decay_i(c_a), .cf_gain_i(c_b), .cf_inv_gain_i(c_bi),
        .cf_slide_i(c_k), .cf_step_i(c_mu), .cf_slope_i(c_g),
        .iest_alpha_o(ie_a), .iest_beta_o(ie_b),
        .emf_alpha_o(ee_a), .emf_beta_o(ee_b), .valid_o(valid)
    );

    function automatic longint sat16(longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic longint th(longint x, longint g);
        longint am, a, ym;
        am = (x < 0) ? -x : x;
        a  = (am * g) >>> 12;
        if (a < 16384)      ym = a;
        else if (a < 49152) ym = 8192 + (a >>> 1);
        else                ym = 32767;
        return (x < 0) ? -ym : ym;
    endfunction

    task automatic model_reset();
        for (int ax = 0; ax < 2; ax++) begin
            m_ie[ax] = 0; m_ee[ax] = 0; m_ep[ax] = 0;
        end
    endtask

    task automatic model_step(int ax, longint im, longint u);
        longint err, kz, kzp, v, inx, d, en;
        err = sat16(m_ie[ax] - im);
        kz  = sat16((longint'(c_k) * th(err, longint'(c_g))) >>> 12);
        kzp = sat16((longint'(c_k) * th(m_ep[ax], longint'(c_g))) >>> 12);
        v   = sat16(u - m_ee[ax] - kz);
        inx = sat16((longint'(c_a) * m_ie[ax] + longint'(c_b) * v) >>> 12);
        d   = sat16((longint'(c_bi) * err - longint'(c_a) * m_ep[ax] + (kzp <<< 12)) >>> 12);
        en  = sat16(m_ee[ax] + sat16((longint'(c_mu) * d) >>> 12));
        m_ie[ax] = inx; m_ee[ax] = en; m_ep[ax] = err;
    endtask

    task automatic check(string what, longint act, longint exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check({tag, " iest_alpha"}, longint'(ie_a), m_ie[0]);
        check({tag, " iest_beta"},  longint'(ie_b), m_ie[1]);
        check({tag, " emf_alpha"},  longint'(ee_a), m_ee[0]);
        check({tag, " emf_beta"},   longint'(ee_b), m_ee[1]);
    endtask

    // Issue one strobe and check the valid timing; optionally strobe while busy.
    task automatic run_vec(int ia, int ib, int va, int vb, bit inject, string tag);
        int first_n = 0;
        int pulses = 0;
        @(negedge clk);
        im_a = 16'(ia); im_b = 16'(ib); u_a = 16'(va); u_b = 16'(vb);
        sample = 1'b1;
        model_step(0, ia, va);
        model_step(1, ib, vb);
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            if (n == 1) sample = 1'b0;
            if (inject && n == 3) begin
                sample = 1'b1;
                im_a = 16'sd20000; im_b = -16'sd20000;
                u_a = -16'sd9000;  u_b = 16'sd9000;
            end
            if (inject && n == 4) sample = 1'b0;
            if (valid) begin
                pulses++;
                if (first_n == 0) begin
                    first_n = n;
                    compare_all(tag);
                end
            end
        end
        check({tag, " R8 valid latency"}, first_n, 8);
        check({tag, " R8 R9 valid pulse count"}, pulses, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_total++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", longint'(valid), 0);
        compare_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6: table walk covering all tanh segments in both signs
        for (int v = 0; v < NVEC; v++)
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0, "R2 R3 R4 R5 R6 table");

        // R9: strobe during a running update is dropped
        run_vec(-3000, 7000, 1500, -2500, 1'b1, "R9 busy strobe");

        // R1 R6: reset mid-run clears estimates and error history
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        compare_all("R1 mid reset");
        rst_n = 1'b1;
        run_vec(VEC[1][0], VEC[1][1], VEC[1][2], VEC[1][3], 1'b0, "R6 history after reset");

        // R7: zero beta stimulus from zero state leaves beta at zero
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        run_vec(9000, 0, 6000, 0, 1'b0, "R7 independence");
        check("R7 beta current stays zero", longint'(ie_b), 0);
        check("R7 beta emf stays zero", longint'(ee_b), 0);

        // R10: rail saturation, coefficients changed while idle (R11)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        c_a = 16'sd0; c_b = 16'sd16384;
        run_vec(0, 0, 32767, -32768, 1'b0, "R10 R11 saturation");
        check("R10 alpha rail high", longint'(ie_a), 32767);
        check("R10 beta rail low", longint'(ie_b), -32768);

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule